// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. On each cycle it reads the instruction word addressed by its program counter from an internal instruction array. It decodes the fixed 32-bit format and reads two source registers. It then computes a result in an arithmetic unit, may read or write an internal data array, writes a result register back, and chooses the next program counter. All of this is done in one combinational pass between two clock edges.

The core recognises seven operations: register add, register subtract, OR with a zero-extended immediate, word load, word store, branch when two registers are equal, and absolute jump. Any other encoding retires as a no-op. The instruction array is loaded by the surrounding environment (a testbench, in this project) before reset is released. The core exposes only a clock, a synchronous reset and debug outputs. The debug outputs give the current instruction address and describe the register write that commits at the next edge.

Top module: `scyc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and every register becomes 0. `dbg_rf_we` is low whenever `rst` is high.
- R2: Opcode bits 31:26 = 000000 with function bits 5:0 = 100000 writes rs+rt into rd. With function bits 5:0 = 100010 it writes rs-rt into rd. The fields are rs = bits 25:21, rt = bits 20:16 and rd = bits 15:11, and results wrap modulo 2^32.
- R3: Opcode 001101 writes rs OR the immediate (bits 15:0) into rt. The immediate is zero-extended to 32 bits.
- R4: Opcode 100011 writes into rt the data word at byte address rs + sign-extended immediate. The word index is taken from byte-address bits above bit 1, modulo the array depth.
- R5: Opcode 101011 writes rt into the data word at the address formed as in R4. It commits no register write, and a later load from that address returns the stored value.
- R6: Opcode 000100 compares rs with rt. If they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. If not, the next PC is PC+4. Neither case writes a register.
- R7: Opcode 000010 sets the next PC to {PC+4 bits 31:28, instruction bits 25:0, 2'b00} and writes no register.
- R8: Register 0 always reads as 0. A write aimed at it is dropped, and `dbg_rf_we` stays low for it.
- R9: Any other opcode, and opcode 000000 with any other function code, writes no register and no data word, and advances the PC by 4.
- R10: `dbg_pc` is the address of the instruction executing in the current cycle. `dbg_rf_we`, `dbg_rf_waddr` and `dbg_rf_wdata` describe the register write that commits at the next edge. Every instruction other than a branch or jump advances the PC by 4, and an instruction sees the value written by the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dbg_pc | output | 32 | Byte address of the instruction executing this cycle |
| dbg_rf_we | output | 1 | A register write commits at the next edge |
| dbg_rf_waddr | output | 5 | Destination register of that write |
| dbg_rf_wdata | output | 32 | Value of that write |

## Verification
The assertions assume that the instruction array holds a stable program whenever reset is low. They also assume that reset is held for at least one edge before any check depends on the PC. The bench meets both conditions: it rewrites the instruction array only while reset is high and releases reset on a falling edge after two rising edges. It keeps every data address inside the array depth, so no store aliases another test location. No program relies on PC bits 31:28 changing, because no reachable branch offset alters them; the jump-target assertion covers how those bits are composed.

// File: rtl/scyc_pkg.sv
package scyc_pkg;

   localparam int XLEN     = 32;
   localparam int REG_AW   = 5;
   localparam int IMM_W    = 16;
   localparam int JIDX_W   = 26;

   localparam logic [5:0] OP_REG   = 6'b000000;
   localparam logic [5:0] OP_ORIMM = 6'b001101;
   localparam logic [5:0] OP_LOAD  = 6'b100011;
   localparam logic [5:0] OP_STORE = 6'b101011;
   localparam logic [5:0] OP_BREQ  = 6'b000100;
   localparam logic [5:0] OP_JUMP  = 6'b000010;

   localparam logic [5:0] FN_ADD   = 6'b100000;
   localparam logic [5:0] FN_SUB   = 6'b100010;

   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_OR  = 2'd2
   } alu_op_e;

   typedef struct packed {
      logic    legal;
      logic    dst_rd;
      logic    b_imm;
      logic    wb_mem;
      logic    reg_wr;
      logic    mem_wr;
      logic    branch;
      logic    jump;
      logic    sext;
      alu_op_e alu_op;
   } ctrl_t;

endpackage

// File: rtl/scyc_decode.sv
module scyc_decode
   import scyc_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctl
);

   always_comb begin
      ctl        = '0;
      ctl.alu_op = ALU_ADD;
      unique case (opcode)
         OP_REG: begin
            unique case (funct)
               FN_ADD: begin
                  ctl.legal  = 1'b1;
                  ctl.dst_rd = 1'b1;
                  ctl.reg_wr = 1'b1;
                  ctl.alu_op = ALU_ADD;
               end
               FN_SUB: begin
                  ctl.legal  = 1'b1;
                  ctl.dst_rd = 1'b1;
                  ctl.reg_wr = 1'b1;
                  ctl.alu_op = ALU_SUB;
               end
               default: ;
            endcase
         end
         OP_ORIMM: begin
            ctl.legal  = 1'b1;
            ctl.b_imm  = 1'b1;
            ctl.reg_wr = 1'b1;
            ctl.alu_op = ALU_OR;
         end
         OP_LOAD: begin
            ctl.legal  = 1'b1;
            ctl.b_imm  = 1'b1;
            ctl.wb_mem = 1'b1;
            ctl.reg_wr = 1'b1;
            ctl.sext   = 1'b1;
         end
         OP_STORE: begin
            ctl.legal  = 1'b1;
            ctl.b_imm  = 1'b1;
            ctl.mem_wr = 1'b1;
            ctl.sext   = 1'b1;
         end
         OP_BREQ: begin
            ctl.legal  = 1'b1;
            ctl.branch = 1'b1;
            ctl.sext   = 1'b1;
            ctl.alu_op = ALU_SUB;
         end
         OP_JUMP: begin
            ctl.legal  = 1'b1;
            ctl.jump   = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/scyc_regfile.sv
module scyc_regfile #(
   parameter int W    = 32,
   parameter int NREG = 32,
   parameter int NRD  = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NRD-1:0][$clog2(NREG)-1:0] raddr,
   output logic [NRD-1:0][W-1:0]    rdata,
   input  logic                     we,
   input  logic [$clog2(NREG)-1:0]  waddr,
   input  logic [W-1:0]             wdata
);

   localparam int AW = $clog2(NREG);

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_depth
      $error("scyc_regfile: NREG must be a power of two of at least 2");
   end
   if (NRD < 1) begin : g_bad_ports
      $error("scyc_regfile: at least one read port is needed");
   end

   logic [W-1:0] regs [NREG];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (we && waddr != '0) begin
         regs[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      logic [AW-1:0] a;
      assign a        = raddr[p];
      assign rdata[p] = (a == '0) ? '0 : regs[a];
   end

endmodule

// File: rtl/scyc_alu.sv
module scyc_alu
   import scyc_pkg::*;
#(
   parameter int W = 32
) (
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y,
   output logic         zero
);

   if (W < 2) begin : g_bad_w
      $error("scyc_alu: width too small");
   end

   always_comb begin
      unique case (op)
         ALU_SUB: y = a - b;
         ALU_OR:  y = a | b;
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/scyc_next_pc.sv
module scyc_next_pc #(
   parameter int W      = 32,
   parameter int JIDX_W = 26
) (
   input  logic [W-1:0]      pc,
   input  logic [W-1:0]      imm_ext,
   input  logic [JIDX_W-1:0] jidx,
   input  logic              take_branch,
   input  logic              jump,
   output logic [W-1:0]      pc_plus4,
   output logic [W-1:0]      pc_next
);

   localparam int TOP_W = W - JIDX_W - 2;

   if (TOP_W < 0) begin : g_bad_jidx
      $error("scyc_next_pc: jump index wider than address");
   end

   logic [W-1:0] br_target;
   logic [W-1:0] j_target;

   assign pc_plus4  = pc + W'(4);
   assign br_target = pc_plus4 + {imm_ext[W-3:0], 2'b00};

   if (TOP_W > 0) begin : g_jtop
      assign j_target = {pc_plus4[W-1 -: TOP_W], jidx, 2'b00};
   end else begin : g_jflat
      assign j_target = {jidx, 2'b00};
   end

   always_comb begin
      if (jump)             pc_next = j_target;
      else if (take_branch) pc_next = br_target;
      else                  pc_next = pc_plus4;
   end

endmodule

// File: rtl/scyc_core.sv
module scyc_core
   import scyc_pkg::*;
#(
   parameter int IMEM_WORDS = 64,
   parameter int DMEM_WORDS = 64,
   parameter int NREG       = 32
) (
   input  logic                clk,
   input  logic                rst,
   output logic [XLEN-1:0]     dbg_pc,
   output logic                dbg_rf_we,
   output logic [REG_AW-1:0]   dbg_rf_waddr,
   output logic [XLEN-1:0]     dbg_rf_wdata
);

   localparam int IA = $clog2(IMEM_WORDS);
   localparam int DA = $clog2(DMEM_WORDS);

   if (IMEM_WORDS < 2 || (IMEM_WORDS & (IMEM_WORDS - 1)) != 0) begin : g_bad_imem
      $error("scyc_core: IMEM_WORDS must be a power of two of at least 2");
   end
   if (DMEM_WORDS < 2 || (DMEM_WORDS & (DMEM_WORDS - 1)) != 0) begin : g_bad_dmem
      $error("scyc_core: DMEM_WORDS must be a power of two of at least 2");
   end
   if (NREG != (1 << REG_AW)) begin : g_bad_nreg
      $error("scyc_core: register count must match the 5-bit register fields");
   end
   if (IA + 2 > XLEN || DA + 2 > XLEN) begin : g_bad_span
      $error("scyc_core: memory larger than address space");
   end

   // Instruction array, loaded from outside while reset is held
   logic [XLEN-1:0] imem [IMEM_WORDS];
   initial begin
      for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
   end

   logic [XLEN-1:0] dmem [DMEM_WORDS];

   logic [XLEN-1:0] pc, pc_next, pc_plus4;
   logic [XLEN-1:0] instr;
   logic [5:0]      f_op, f_fn;
   logic [REG_AW-1:0] f_rs, f_rt, f_rd;
   logic [IMM_W-1:0]  f_imm;
   ctrl_t           ctl;

   assign instr = imem[pc[IA+1:2]];
   assign f_op  = instr[31:26];
   assign f_rs  = instr[25:21];
   assign f_rt  = instr[20:16];
   assign f_rd  = instr[15:11];
   assign f_imm = instr[15:0];
   assign f_fn  = instr[5:0];

   scyc_decode u_decode (
      .opcode (f_op),
      .funct  (f_fn),
      .ctl    (ctl)
   );

   logic [1:0][REG_AW-1:0] rf_raddr;
   logic [1:0][XLEN-1:0]   rf_rdata;
   logic [XLEN-1:0]        rs_val, rt_val;
   logic [REG_AW-1:0]      wb_addr;
   logic [XLEN-1:0]        wb_data;
   logic                   rf_commit;

   assign rf_raddr[0] = f_rs;
   assign rf_raddr[1] = f_rt;
   assign rs_val      = rf_rdata[0];
   assign rt_val      = rf_rdata[1];

   scyc_regfile #(
      .W    (XLEN),
      .NREG (NREG),
      .NRD  (2)
   ) u_regfile (
      .clk   (clk),
      .rst   (rst),
      .raddr (rf_raddr),
      .rdata (rf_rdata),
      .we    (rf_commit),
      .waddr (wb_addr),
      .wdata (wb_data)
   );

   logic [XLEN-1:0] imm_ext, alu_b, alu_y;
   logic            alu_zero;

   assign imm_ext = ctl.sext ? {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm}
                             : {{(XLEN-IMM_W){1'b0}}, f_imm};
   assign alu_b   = ctl.b_imm ? imm_ext : rt_val;

   scyc_alu #(.W(XLEN)) u_alu (
      .op   (ctl.alu_op),
      .a    (rs_val),
      .b    (alu_b),
      .y    (alu_y),
      .zero (alu_zero)
   );

   logic [DA-1:0]   d_idx;
   logic [XLEN-1:0] d_rdata;

   assign d_idx   = alu_y[DA+1:2];
   assign d_rdata = dmem[d_idx];

   always_ff @(posedge clk) begin
      if (!rst && ctl.mem_wr) dmem[d_idx] <= rt_val;
   end

   assign wb_addr   = ctl.dst_rd ? f_rd : f_rt;
   assign wb_data   = ctl.wb_mem ? d_rdata : alu_y;
   assign rf_commit = ctl.reg_wr && (wb_addr != '0) && !rst;

   scyc_next_pc #(
      .W      (XLEN),
      .JIDX_W (JIDX_W)
   ) u_next_pc (
      .pc          (pc),
      .imm_ext     (imm_ext),
      .jidx        (instr[JIDX_W-1:0]),
      .take_branch (ctl.branch && alu_zero),
      .jump        (ctl.jump),
      .pc_plus4    (pc_plus4),
      .pc_next     (pc_next)
   );

   always_ff @(posedge clk) begin
      if (rst) pc <= '0;
      else     pc <= pc_next;
   end

   assign dbg_pc       = pc;
   assign dbg_rf_we    = rf_commit;
   assign dbg_rf_waddr = wb_addr;
   assign dbg_rf_wdata = wb_data;

   logic unused_bits;
   assign unused_bits = ^{instr[10:6], alu_y[XLEN-1:DA+2], alu_y[1:0]};

   // ---------------- assertions ----------------
   AST_RESET_PC_ZERO: assert property (@(posedge clk)
      rst |=> (pc == '0)); // R1

   AST_NO_STROBE_IN_RESET: assert property (@(posedge clk)
      rst |-> !dbg_rf_we); // R1

   AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
      ctl.mem_wr |-> !dbg_rf_we); // R5

   AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
      (ctl.branch && rs_val == rt_val) |=>
         (pc == $past(pc) + 32'd4 + {$past(imm_ext[XLEN-3:0]), 2'b00})); // R6

   AST_BRANCH_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
      (ctl.branch && rs_val != rt_val) |=> (pc == $past(pc) + 32'd4)); // R6

   AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
      ctl.jump |=> (pc == {$past(pc_plus4[XLEN-1:XLEN-4]),
                           $past(instr[JIDX_W-1:0]), 2'b00})); // R7

   AST_R0_NEVER_STROBED: assert property (@(posedge clk) disable iff (rst)
      dbg_rf_we |-> (dbg_rf_waddr != '0)); // R8

   AST_NOOP_QUIET: assert property (@(posedge clk) disable iff (rst)
      !ctl.legal |-> (!dbg_rf_we && !ctl.mem_wr)); // R9

   AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (!ctl.branch && !ctl.jump) |=> (pc == $past(pc) + 32'd4)); // R10

   AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      pc[1:0] == 2'b00); // R10

endmodule

// File: tb/scyc_core_bench.sv
module scyc_core_bench;

   localparam int CLK_NS = 20;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] dbg_pc;
   logic        dbg_rf_we;
   logic [4:0]  dbg_rf_waddr;
   logic [31:0] dbg_rf_wdata;

   int checks   = 0;
   int failures = 0;

   always #(CLK_NS/2) clk = ~clk;

   scyc_core u_scyc_core (
      .clk          (clk),
      .rst          (rst),
      .dbg_pc       (dbg_pc),
      .dbg_rf_we    (dbg_rf_we),
      .dbg_rf_waddr (dbg_rf_waddr),
      .dbg_rf_wdata (dbg_rf_wdata)
   );

   // ---- encoders (from the encodings in the requirements) ----
   function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
      return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction
   function automatic logic [31:0] enc_j(input logic [25:0] idx);
      return {6'b000010, idx};
   endfunction

   localparam logic [5:0] ADD = 6'b100000, SUB = 6'b100010;
   localparam logic [5:0] ORI = 6'b001101, LW = 6'b100011, SW = 6'b101011;
   localparam logic [5:0] BEQ = 6'b000100;

   logic [31:0] prog [16];

   task automatic load_and_reset(input int n);
      rst = 1'b1;
      for (int i = 0; i < 64; i++) u_scyc_core.imem[i] = (i < n) ? prog[i] : 32'h0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      checks++;
      if (dbg_pc !== 32'h0 || dbg_rf_we !== 1'b0) begin
         failures++;
         $display("FAIL R1 reset: pc=%h we=%b expected pc=0 we=0", dbg_pc, dbg_rf_we);
      end
      rst = 1'b0;
      #1;
   endtask

   // Check the current cycle, then advance one clock
   task automatic step(input logic [31:0] e_pc, input logic e_we, input int e_wa,
                       input logic [31:0] e_wd, input string req);
      checks++;
      if (dbg_pc !== e_pc || dbg_rf_we !== e_we ||
          (e_we && (dbg_rf_waddr !== 5'(e_wa) || dbg_rf_wdata !== e_wd))) begin
         failures++;
         $display("FAIL %s: pc=%h we=%b wa=%0d wd=%h expected pc=%h we=%b wa=%0d wd=%h",
                  req, dbg_pc, dbg_rf_we, dbg_rf_waddr, dbg_rf_wdata, e_pc, e_we, e_wa, e_wd);
      end
      @(negedge clk);
      #1;
   endtask

   task automatic test_arith;
      prog[0] = enc_i(ORI, 0, 1, 16'h1234);
      prog[1] = enc_i(ORI, 0, 2, 16'hFFFF);
      prog[2] = enc_r(ADD, 1, 2, 3);
      prog[3] = enc_r(SUB, 1, 2, 4);
      prog[4] = enc_r(ADD, 1, 1, 0);
      prog[5] = enc_r(ADD, 0, 1, 5);
      prog[6] = enc_r(SUB, 1, 1, 6);
      prog[7] = enc_r(ADD, 8, 9, 7);
      load_and_reset(8);
      step(32'd0,  1, 1, 32'h0000_1234, "R3 ori");
      step(32'd4,  1, 2, 32'h0000_FFFF, "R3 ori zero-extend");
      step(32'd8,  1, 3, 32'h0001_1233, "R2 add");
      step(32'd12, 1, 4, 32'hFFFF_1235, "R2 sub wrap");
      step(32'd16, 0, 0, 32'h0,         "R8 write to r0 dropped");
      step(32'd20, 1, 5, 32'h0000_1234, "R8 r0 reads zero");
      step(32'd24, 1, 6, 32'h0,         "R2 sub equal");
      step(32'd28, 1, 7, 32'h0,         "R1 registers cleared");
      step(32'd32, 0, 0, 32'h0,         "R10 sequential advance");
   endtask

   task automatic test_memory;
      prog[0] = enc_i(ORI, 0, 1, 16'h0040);
      prog[1] = enc_i(ORI, 0, 2, 16'hBEEF);
      prog[2] = enc_i(SW, 1, 2, 16'h0004);
      prog[3] = enc_i(LW, 1, 3, 16'h0004);
      prog[4] = enc_i(ORI, 0, 4, 16'h0050);
      prog[5] = enc_i(LW, 4, 5, 16'hFFF4);
      prog[6] = enc_i(SW, 1, 4, 16'hFFFC);
      prog[7] = enc_i(LW, 1, 6, 16'hFFFC);
      prog[8] = enc_i(LW, 1, 0, 16'h0004);
      load_and_reset(9);
      step(32'd0,  1, 1, 32'h40,   "R10 setup");
      step(32'd4,  1, 2, 32'hBEEF, "R10 setup");
      step(32'd8,  0, 0, 32'h0,    "R5 store no reg write");
      step(32'd12, 1, 3, 32'hBEEF, "R4 R5 load after store");
      step(32'd16, 1, 4, 32'h50,   "R10 setup");
      step(32'd20, 1, 5, 32'hBEEF, "R4 negative offset");
      step(32'd24, 0, 0, 32'h0,    "R5 store negative offset");
      step(32'd28, 1, 6, 32'h50,   "R5 stored value");
      step(32'd32, 0, 0, 32'h0,    "R8 load to r0 dropped");
   endtask

   task automatic test_branch;
      prog[0] = enc_i(ORI, 0, 1, 16'd5);
      prog[1] = enc_i(ORI, 0, 2, 16'd5);
      prog[2] = enc_i(BEQ, 1, 2, 16'd2);
      prog[3] = enc_i(ORI, 0, 9, 16'd1);
      prog[4] = enc_i(ORI, 0, 9, 16'd2);
      prog[5] = enc_i(BEQ, 1, 0, 16'd5);
      prog[6] = enc_i(BEQ, 0, 0, 16'hFFF9);
      load_and_reset(7);
      step(32'd0,  1, 1, 32'd5, "R10 setup");
      step(32'd4,  1, 2, 32'd5, "R10 setup");
      step(32'd8,  0, 0, 32'h0, "R6 beq taken");
      step(32'd20, 0, 0, 32'h0, "R6 beq target");
      step(32'd24, 0, 0, 32'h0, "R6 beq not taken");
      step(32'd0,  1, 1, 32'd5, "R6 backward branch");
   endtask

   task automatic test_jump;
      prog[0] = enc_j(26'd4);
      prog[4] = enc_i(ORI, 0, 1, 16'h0003);
      prog[5] = enc_j(26'd0);
      prog[1] = enc_i(ORI, 0, 9, 16'h0001);
      prog[2] = 32'h0;
      prog[3] = 32'h0;
      load_and_reset(6);
      step(32'd0,  0, 0, 32'h0, "R7 jump no write");
      step(32'd16, 1, 1, 32'h3, "R7 jump target");
      step(32'd20, 0, 0, 32'h0, "R7 jump back");
      step(32'd0,  0, 0, 32'h0, "R7 jump to zero");
   endtask

   task automatic test_noop;
      prog[0] = enc_i(ORI, 0, 1, 16'h0077);
      prog[1] = enc_i(SW, 0, 1, 16'h0008);
      prog[2] = {6'b111011, 5'd0, 5'd0, 16'h0008};
      prog[3] = enc_r(6'b100001, 1, 1, 7);
      prog[4] = 32'h0;
      prog[5] = enc_i(LW, 0, 3, 16'h0008);
      load_and_reset(6);
      step(32'd0,  1, 1, 32'h77, "R10 setup");
      step(32'd4,  0, 0, 32'h0,  "R5 store");
      step(32'd8,  0, 0, 32'h0,  "R9 unknown opcode");
      step(32'd12, 0, 0, 32'h0,  "R9 unknown function");
      step(32'd16, 0, 0, 32'h0,  "R9 all-zero word");
      step(32'd20, 1, 3, 32'h77, "R9 no store by no-op");
   endtask

   task automatic report;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #1;
      test_arith();
      test_memory();
      test_branch();
      test_jump();
      test_noop();
      report();
   end

   initial begin
      #(CLK_NS * 150000);
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
   end

endmodule